// File: doc/BRIEF.md
# Power-Management Event Interrupt Router

This block holds two 16-bit registers behind a small synchronous register port: an event-enable register and a power-management control register. It takes five externally held event status levels: periodic timer, global, power button, sleep button and alarm. Each status is gated by its own enable bit. The result is routed onto one of two level interrupt lines. One line goes to the operating system's event handler (`irq_os`). The other goes to the platform firmware's management handler (`irq_fw`). A route-select bit in the control register picks the line for the button and alarm events. The timer and global events always go to the operating-system line.

The control register also carries three more functions. The first is a release handshake: software sets a bit, the block raises a flag towards firmware, and the bit drops when firmware clears that flag. The second is a plain bus-master reload storage bit. The third is a sleep command: writing the go bit emits a single-cycle sleep request carrying a 3-bit sleep type, and a marker is raised when that type is one of the reserved codes. The status sources, the sleep sequencer and the power rails sit outside this block.

Top module: `pmr_event_router`

## Requirements
- R1: After a synchronous active-high reset, both registers read 0000h and `irq_os`, `irq_fw`, `fw_flag`, `slp_req`, `slp_type`, `slp_type_rsvd` and `reg_rdata` are 0.
- R2: The enable register sits at byte offset 02h. Its writable bits are timer enable (bit 0), global enable (bit 5), power-button enable (bit 8), sleep-button enable (bit 9) and alarm enable (bit 10). All other bits read 0 and ignore writes.
- R3: The control register sits at byte offset 04h. Bit 0 is the route select, bit 1 is bus-master reload and bits 12:10 are the sleep type, all plain read-write storage. Bits 9:3, 13, 14 and 15 read 0. Reads of any other offset return 0, and writes to any other offset change no state.
- R4: A set timer status with enable bit 0 set, or a set global status with enable bit 5 set, drives `irq_os` high whatever the route select holds.
- R5: A set power-button, sleep-button or alarm status with its enable bit set drives `irq_os` when the route select is 1 and `irq_fw` when it is 0.
- R6: `irq_os` and `irq_fw` are registered levels. The value after a clock edge reflects the status inputs and register contents sampled at that edge, and the level stays high for as long as a qualifying event stays set.
- R7: Control bit 2 (release) is set by writing 1 and is unchanged by writing 0. `fw_flag` follows it. A `fw_flag_clr` pulse clears it. A setting write and a clear in the same cycle leave it set.
- R8: Writing 1 to control bit 13 makes `slp_req` high for exactly the cycle after the write, with `slp_type` equal to the written bits 12:10. While `slp_req` is low, `slp_type` is 0.
- R9: When the requested sleep type is 2, 3 or 4, `slp_type_rsvd` is high together with `slp_req`. For types 0, 1, 5, 6 and 7 it stays low.
- R10: `reg_rdata` is registered. It shows the contents, before that edge, of the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| st_timer | input | 1 | Timer event status |
| st_global | input | 1 | Global event status |
| st_power_btn | input | 1 | Power-button event status |
| st_sleep_btn | input | 1 | Sleep-button event status |
| st_alarm | input | 1 | Alarm event status |
| fw_flag_clr | input | 1 | Firmware clears its release flag |
| fw_flag | output | 1 | Release flag towards firmware |
| irq_os | output | 1 | Operating-system event interrupt level |
| irq_fw | output | 1 | Firmware management interrupt level |
| slp_req | output | 1 | One-cycle sleep request |
| slp_type | output | 3 | Sleep type carried by the request |
| slp_type_rsvd | output | 1 | Requested sleep type is reserved |

## Verification
A write changes a register at the edge that samples it. A status change reaches `irq_os` or `irq_fw` one edge after it is sampled, so a newly written enable shows on the interrupt lines one edge after the write. `slp_req`, `slp_type_rsvd` and `fw_flag` move at the write edge itself, and `reg_rdata` appears one edge after the address. The bench drives every input at the falling edge and computes the expected outputs from its own copy of the registers and the pre-edge inputs. It then advances that copy and compares one time unit after the next rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned EV_N   = 5;
  localparam int unsigned TYPE_W = 3;

  localparam logic [ADDR_W-1:0] EN_OFF   = 8'h02;
  localparam logic [ADDR_W-1:0] CTRL_OFF = 8'h04;

  // event order: timer, global, power button, sleep button, alarm
  localparam int unsigned EV_EN_BIT [EV_N] = '{0, 5, 8, 9, 10};
  localparam logic [EV_N-1:0] EV_FORCE_OS = 5'b00011;

  localparam int unsigned SEL_BIT   = 0;
  localparam int unsigned BMR_BIT   = 1;
  localparam int unsigned REL_BIT   = 2;
  localparam int unsigned TYPE_LO   = 10;
  localparam int unsigned GO_BIT    = 13;

  function automatic logic [DATA_W-1:0] en_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < EV_N; i++) m[EV_EN_BIT[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic type_is_rsvd(input logic [TYPE_W-1:0] t);
    return (t >= 3'd2) && (t <= 3'd4);
  endfunction
endpackage

// File: rtl/pmr_enable_reg.sv
module pmr_enable_reg
  import pmr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  localparam logic [DATA_W-1:0] MASK = en_mask();

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_store
      always_ff @(posedge clk) begin
        if (rst)         en_q[i] <= 1'b0;
        else if (wr_hit) en_q[i] <= wdata[i];
      end
    end else begin : g_zero
      assign en_q[i] = 1'b0;
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~MASK[W-1:0]) == '0);
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_hit) && !$past(rst) |-> $stable(en_q));
endmodule

// File: rtl/pmr_control_reg.sv
module pmr_control_reg
  import pmr_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned TW = TYPE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [W-1:0]  wdata,
  input  logic          fw_clr,
  output logic          sel_q,
  output logic          bmr_q,
  output logic          rel_q,
  output logic [TW-1:0] type_q,
  output logic          req_q,
  output logic [TW-1:0] req_type_q,
  output logic          req_rsvd_q
);
  logic          set_rel;
  logic          go;
  logic [TW-1:0] wtype;

  assign set_rel = wr_hit && wdata[REL_BIT];
  assign go      = wr_hit && wdata[GO_BIT];
  assign wtype   = wdata[TYPE_LO +: TW];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      bmr_q  <= 1'b0;
      type_q <= '0;
    end else if (wr_hit) begin
      sel_q  <= wdata[SEL_BIT];
      bmr_q  <= wdata[BMR_BIT];
      type_q <= wtype;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rel_q <= 1'b0;
    else if (set_rel) rel_q <= 1'b1;
    else if (fw_clr)  rel_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      req_type_q <= '0;
      req_rsvd_q <= 1'b0;
    end else begin
      req_q      <= go;
      req_type_q <= go ? wtype : '0;
      req_rsvd_q <= go && type_is_rsvd(wtype);
    end
  end

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    $past(fw_clr && !set_rel) && !$past(rst) |-> !rel_q);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    $past(set_rel) && !$past(rst) |-> rel_q);
  a_r8_req_from_write: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(wr_hit && wdata[GO_BIT]));
  a_r8_type_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !req_q |-> req_type_q == '0);
  a_r9_rsvd_with_req: assert property (@(posedge clk) disable iff (rst)
    req_rsvd_q |-> req_q);
endmodule

// File: rtl/pmr_irq_route.sv
module pmr_irq_route
  import pmr_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned N = EV_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] en,
  input  logic         sel,
  input  logic [N-1:0] status,
  output logic         irq_os,
  output logic         irq_fw
);
  logic [N-1:0] live;
  logic [N-1:0] to_os;
  logic [N-1:0] to_fw;

  for (genvar e = 0; e < N; e++) begin : g_ev
    assign live[e] = status[e] && en[EV_EN_BIT[e]];
    if (EV_FORCE_OS[e]) begin : g_fixed
      assign to_os[e] = live[e];
      assign to_fw[e] = 1'b0;
    end else begin : g_steered
      assign to_os[e] = live[e] && sel;
      assign to_fw[e] = live[e] && !sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_os <= 1'b0;
      irq_fw <= 1'b0;
    end else begin
      irq_os <= |to_os;
      irq_fw <= |to_fw;
    end
  end

  a_r4_timer_forces_os: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(status[0] && en[EV_EN_BIT[0]]) |-> irq_os);
  a_r4_global_forces_os: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(status[1] && en[EV_EN_BIT[1]]) |-> irq_os);
  a_r5_fw_needs_sel_low: assert property (@(posedge clk) disable iff (rst)
    irq_fw |-> !$past(sel));
  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(live == '0) |-> !irq_os && !irq_fw);
endmodule

// File: rtl/pmr_event_router.sv
module pmr_event_router
  import pmr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned TW = TYPE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          st_timer,
  input  logic          st_global,
  input  logic          st_power_btn,
  input  logic          st_sleep_btn,
  input  logic          st_alarm,
  input  logic          fw_flag_clr,
  output logic          fw_flag,
  output logic          irq_os,
  output logic          irq_fw,
  output logic          slp_req,
  output logic [TW-1:0] slp_type,
  output logic          slp_type_rsvd
);
  localparam int unsigned N = EV_N;

  logic          hit_en, hit_ctrl;
  logic [DW-1:0] en_q;
  logic          sel_q, bmr_q, rel_q;
  logic [TW-1:0] type_q;
  logic [DW-1:0] ctrl_view;
  logic [N-1:0]  status;

  assign hit_en   = reg_we && (reg_addr == EN_OFF[AW-1:0]);
  assign hit_ctrl = reg_we && (reg_addr == CTRL_OFF[AW-1:0]);
  assign status   = {st_alarm, st_sleep_btn, st_power_btn, st_global, st_timer};

  pmr_enable_reg #(.W(DW)) u_en (
    .clk(clk), .rst(rst), .wr_hit(hit_en), .wdata(reg_wdata), .en_q(en_q)
  );

  pmr_control_reg #(.W(DW), .TW(TW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(hit_ctrl), .wdata(reg_wdata),
    .fw_clr(fw_flag_clr), .sel_q(sel_q), .bmr_q(bmr_q), .rel_q(rel_q),
    .type_q(type_q), .req_q(slp_req), .req_type_q(slp_type),
    .req_rsvd_q(slp_type_rsvd)
  );

  pmr_irq_route #(.W(DW), .N(N)) u_route (
    .clk(clk), .rst(rst), .en(en_q), .sel(sel_q), .status(status),
    .irq_os(irq_os), .irq_fw(irq_fw)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[SEL_BIT] = sel_q;
    ctrl_view[BMR_BIT] = bmr_q;
    ctrl_view[REL_BIT] = rel_q;
    ctrl_view[TYPE_LO +: TW] = type_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                                reg_rdata <= '0;
    else if (reg_addr == EN_OFF[AW-1:0])    reg_rdata <= en_q;
    else if (reg_addr == CTRL_OFF[AW-1:0])  reg_rdata <= ctrl_view;
    else                                    reg_rdata <= '0;
  end

  assign fw_flag = rel_q;

  a_r3_go_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[GO_BIT] && reg_rdata[DW-1:DW-2] == 2'b00);
  a_r10_other_offset_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(reg_addr != EN_OFF[AW-1:0] && reg_addr != CTRL_OFF[AW-1:0])
    |-> reg_rdata == '0);
endmodule

// File: tb/test_pmr_event_router.sv
module test_pmr_event_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        st_timer = 0, st_global = 0, st_power_btn = 0, st_sleep_btn = 0, st_alarm = 0;
  logic        fw_flag_clr = 1'b0;
  logic        fw_flag, irq_os, irq_fw, slp_req, slp_type_rsvd;
  logic [2:0]  slp_type;

  int checks = 0;
  int errors = 0;

  // bench copy of the register state
  logic [15:0] m_en = '0;
  logic        m_sel = 0, m_bmr = 0, m_rel = 0;
  logic [2:0]  m_type = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmr_event_router i_pmr_event_router (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_timer(st_timer),
    .st_global(st_global), .st_power_btn(st_power_btn),
    .st_sleep_btn(st_sleep_btn), .st_alarm(st_alarm),
    .fw_flag_clr(fw_flag_clr), .fw_flag(fw_flag), .irq_os(irq_os),
    .irq_fw(irq_fw), .slp_req(slp_req), .slp_type(slp_type),
    .slp_type_rsvd(slp_type_rsvd)
  );

  function automatic logic [15:0] ctrl_word(input logic s, input logic b,
                                            input logic r, input logic [2:0] t);
    return {3'b000, t, 7'b0, r, b, s};
  endfunction

  function automatic logic exp_os(input logic [15:0] en, input logic sel);
    logic steer;
    steer = (st_power_btn & en[8]) | (st_sleep_btn & en[9]) | (st_alarm & en[10]);
    return (st_timer & en[0]) | (st_global & en[5]) | (sel & steer);
  endfunction

  function automatic logic exp_fw(input logic [15:0] en, input logic sel);
    return !sel & ((st_power_btn & en[8]) | (st_sleep_btn & en[9]) | (st_alarm & en[10]));
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; predict, advance, compare after the edge
  task automatic step();
    logic [15:0] e_rd;
    logic e_os, e_fw, e_req, e_rsvd;
    logic [2:0] e_type;
    logic wen, wct;
    if (reg_addr == 8'h02)      e_rd = m_en;
    else if (reg_addr == 8'h04) e_rd = ctrl_word(m_sel, m_bmr, m_rel, m_type);
    else                        e_rd = '0;
    e_os = exp_os(m_en, m_sel);
    e_fw = exp_fw(m_en, m_sel);
    wen = reg_we && reg_addr == 8'h02;
    wct = reg_we && reg_addr == 8'h04;
    e_req  = wct && reg_wdata[13];
    e_type = e_req ? reg_wdata[12:10] : 3'd0;
    e_rsvd = e_req && (reg_wdata[12:10] inside {3'd2, 3'd3, 3'd4});
    if (wen) m_en = reg_wdata & 16'h0721;
    if (wct) begin
      m_sel = reg_wdata[0]; m_bmr = reg_wdata[1]; m_type = reg_wdata[12:10];
    end
    if (wct && reg_wdata[2]) m_rel = 1'b1;
    else if (fw_flag_clr)    m_rel = 1'b0;
    @(posedge clk); #1;
    chk("R10 R2 R3 readback", reg_rdata, e_rd);
    chk("R4 R5 R6 irq_os", {15'b0, irq_os}, {15'b0, e_os});
    chk("R5 R6 irq_fw", {15'b0, irq_fw}, {15'b0, e_fw});
    chk("R7 fw_flag", {15'b0, fw_flag}, {15'b0, m_rel});
    chk("R8 slp_req", {15'b0, slp_req}, {15'b0, e_req});
    chk("R8 slp_type", {13'b0, slp_type}, {13'b0, e_type});
    chk("R9 slp_type_rsvd", {15'b0, slp_type_rsvd}, {15'b0, e_rsvd});
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] a, input logic we, input logic [15:0] d,
                       input logic [4:0] st, input logic clr);
    reg_addr = a; reg_we = we; reg_wdata = d; fw_flag_clr = clr;
    {st_alarm, st_sleep_btn, st_power_btn, st_global, st_timer} = st;
    step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    logic [7:0] a;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, read both registers
    chk("R1 irq_os", {15'b0, irq_os}, 16'h0);
    chk("R1 irq_fw", {15'b0, irq_fw}, 16'h0);
    chk("R1 slp_req", {15'b0, slp_req}, 16'h0);
    chk("R1 fw_flag", {15'b0, fw_flag}, 16'h0);
    chk("R1 rdata", reg_rdata, 16'h0);
    drive(8'h02, 0, 16'h0, 5'h1f, 0);
    drive(8'h04, 0, 16'h0, 5'h1f, 0);
    // R2: all ones into enable, reserved bits must read 0
    drive(8'h02, 1, 16'hffff, 5'h00, 0);
    drive(8'h02, 0, 16'h0, 5'h00, 0);
    chk("R2 masked enable value", reg_rdata, 16'h0721);
    // R5: route select 0, button goes to firmware line
    drive(8'h04, 1, 16'h0000, 5'b00100, 0);
    drive(8'h04, 0, 16'h0, 5'b00100, 0);
    chk("R5 button to fw", {15'b0, irq_fw}, 16'h1);
    // R4: timer goes to OS line with select 0
    drive(8'h00, 0, 16'h0, 5'b00001, 0);
    drive(8'h00, 0, 16'h0, 5'b00001, 0);
    chk("R4 timer to os with select 0", {15'b0, irq_os}, 16'h1);
    // R3: writes elsewhere ignored
    drive(8'h06, 1, 16'hffff, 5'h0, 0);
    drive(8'h04, 0, 16'h0, 5'h0, 0);
    chk("R3 stray write ignored", reg_rdata, 16'h0000);
    // R7: set, write 0 keeps, set+clear keeps, clear drops
    drive(8'h04, 1, 16'h0004, 5'h0, 0);
    drive(8'h04, 1, 16'h0000, 5'h0, 0);
    chk("R7 write 0 keeps release", {15'b0, fw_flag}, 16'h1);
    drive(8'h04, 1, 16'h0004, 5'h0, 1);
    chk("R7 set beats clear", {15'b0, fw_flag}, 16'h1);
    drive(8'h00, 0, 16'h0, 5'h0, 1);
    chk("R7 clear drops", {15'b0, fw_flag}, 16'h0);
    // R8 R9: every sleep type, go bit reads back 0
    for (int t = 0; t < 8; t++) begin
      drive(8'h04, 1, 16'(16'h2000 | (t << 10)), 5'h0, 0);
      chk("R9 reserved type flag", {15'b0, slp_type_rsvd},
          {15'b0, (t >= 2 && t <= 4) ? 1'b1 : 1'b0});
      drive(8'h04, 0, 16'h0, 5'h0, 0);
      chk("R8 single pulse", {15'b0, slp_req}, 16'h0);
    end
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 4)
        0: a = 8'h02;
        1: a = 8'h04;
        2: a = 8'h00;
        default: a = 8'($urandom);
      endcase
      drive(a, ($urandom % 3) == 0, 16'($urandom), 5'($urandom),
            ($urandom % 6) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule